// File: doc/BRIEF.md
# MDIO Management Master with Packed Command Register

This block drives a clause-22 management bus (MDC clock, bidirectional MDIO data) from a single 32-bit command/status word. Software writes one word that holds a go flag, a direction flag, a 5-bit PHY address, a 5-bit register address and 16 bits of data. If the go flag is set and no transaction is running, the block sends a complete 64-bit management frame. While the frame is on the wire, the go flag reads back as 1, so the same bit works as the busy indicator. Software polls it before it issues a command and again before it takes read data.

MDC is the system clock divided down by the `CLK_DIV` parameter, with each MDC half-period lasting `CLK_DIV` system cycles. MDIO changes when MDC falls, and read data is sampled when MDC rises. On a read, the block releases MDIO through `mdio_oe` for the turnaround and data bits. It shifts in the sixteen returned bits and places them in the low half of the word at the moment the busy bit drops.

The sequencer is a named state machine with these states: `ST_IDLE`, `ST_PREAMBLE` (32 ones), `ST_START` (01), `ST_OPCODE` (10 read, 01 write), `ST_PHYADDR`, `ST_REGADDR`, `ST_TURN` and `ST_DATA`. The transitions are listed below.
- `ST_IDLE` to `ST_PREAMBLE` on an accepted command.
- Each state advances to the next one on the MDC falling edge that ends its last bit, after bit indices 31, 33, 35, 40, 45 and 47.
- `ST_DATA` to `ST_IDLE` on the falling edge that ends bit 63.

Top module: `mdio_cmd_master`

## Requirements
- R1: `reg_rdata` packs busy at bit 31, direction at bit 30 (1 = read, 0 = write), zeros at bits 29:26, PHY address at 25:21, register address at 20:16 and data at 15:0. After reset the whole word is 0.
- R2: A write with `reg_wdata[31]`=1 while idle is accepted at that clock edge. From the next cycle, bit 31 reads 1, `mdc` is 0, and `mdio_oe`=1 with `mdio_o`=1.
- R3: Counting edges from the accepting edge (edge 0), `mdc` equals bit 0 of (n / CLK_DIV) after edge n. Busy stays set for exactly 128*CLK_DIV cycles.
- R4: During frame bit k, where k = n / (2*CLK_DIV), the bits go out in this order, MSB first:
  - bits 0–31: 32 ones;
  - bits 32–33: 01;
  - bits 34–35: opcode, 10 for a read or 01 for a write;
  - bits 36–40: PHY address;
  - bits 41–45: register address;
  - bits 46–47: turnaround, driven as 10 on a write;
  - bits 48–63: the 16 write-data bits.
- R5: While it is driven, `mdio_o` changes only on the system edge at which `mdc` falls.
- R6: A write drives `mdio_oe` for all 64 bits. A read drives it only for bits 0–45 and releases it from bit 46 to the end.
- R7: A read samples `mdio_i` at each of the 16 MDC rising edges in bits 48–63, MSB first. The value appears in bits 15:0 in the same cycle that bit 31 clears, and the other fields keep their command values.
- R8: A write while busy is ignored, and so is a write with bit 31 = 0. In either case `reg_rdata` and the running frame are unchanged.
- R9: Whenever the block is idle, including right after a frame, `mdc` is 0 and `mdio_oe` is 0. A new command can be accepted at the first edge after busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word being written |
| reg_rdata | output | 32 | Command/status word read back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench builds the block with `CLK_DIV` = 3, which is odd and not a power of two. This means the divider wrap and the bit-boundary arithmetic cannot hide behind bit selects, and every half-period spans several system cycles in which MDIO must hold still. One frame then takes 384 cycles. That keeps writes and reads with contrasting address and data patterns, a write issued mid-frame, a write without the go flag, and a command issued on the very edge busy clears all within a short run.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int REQ_POS    = 31;
    localparam int RD_POS     = 30;
    localparam int PHY_LSB    = 21;
    localparam int REG_LSB    = 16;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int BODY_BITS  = 2 + 2 + ADDR_W + ADDR_W + 2 + DATA_W;
    localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam int END_PRE   = PRE_BITS - 1;
    localparam int END_START = END_PRE + 2;
    localparam int END_OP    = END_START + 2;
    localparam int END_PHY   = END_OP + ADDR_W;
    localparam int END_REG   = END_PHY + ADDR_W;
    localparam int END_TURN  = END_REG + 2;
    localparam int END_FRAME = FRAME_BITS - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYADDR,
        ST_REGADDR,
        ST_TURN,
        ST_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int CLK_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == CNT_LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] I_PRE   = IDX_W'(END_PRE);
    localparam logic [IDX_W-1:0] I_START = IDX_W'(END_START);
    localparam logic [IDX_W-1:0] I_OP    = IDX_W'(END_OP);
    localparam logic [IDX_W-1:0] I_PHY   = IDX_W'(END_PHY);
    localparam logic [IDX_W-1:0] I_REG   = IDX_W'(END_REG);
    localparam logic [IDX_W-1:0] I_TURN  = IDX_W'(END_TURN);
    localparam logic [IDX_W-1:0] I_LAST  = IDX_W'(END_FRAME);

    mdio_state_e          state, state_nxt;
    logic [IDX_W-1:0]     bidx;
    logic [BODY_BITS-1:0] shreg;
    logic                 rd_q;

    assign active = (state != ST_IDLE);
    assign done   = fall_tick && (state == ST_DATA) && (bidx == I_LAST);

    // next phase once the current bit ends
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     state_nxt = ST_IDLE;
            ST_PREAMBLE: if (bidx == I_PRE)   state_nxt = ST_START;
            ST_START:    if (bidx == I_START) state_nxt = ST_OPCODE;
            ST_OPCODE:   if (bidx == I_OP)    state_nxt = ST_PHYADDR;
            ST_PHYADDR:  if (bidx == I_PHY)   state_nxt = ST_REGADDR;
            ST_REGADDR:  if (bidx == I_REG)   state_nxt = ST_TURN;
            ST_TURN:     if (bidx == I_TURN)  state_nxt = ST_DATA;
            ST_DATA:     state_nxt = ST_DATA;
        endcase
    end

    // state register and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            bidx  <= '0;
        end else if (start && !active) begin
            state <= ST_PREAMBLE;
            bidx  <= '0;
        end else if (fall_tick) begin
            if (done) begin
                state <= ST_IDLE;
                bidx  <= '0;
            end else begin
                state <= state_nxt;
                bidx  <= bidx + 1'b1;
            end
        end
    end

    // outgoing shift register and incoming capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            rd_data <= '0;
            rd_q    <= 1'b0;
        end else if (start && !active) begin
            shreg <= {2'b01, (is_read ? 2'b10 : 2'b01), phy_addr, reg_addr,
                      2'b10, wr_data};
            rd_q  <= is_read;
        end else begin
            if (rise_tick && state == ST_DATA)
                rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            if (fall_tick && state != ST_PREAMBLE && !done)
                shreg <= {shreg[BODY_BITS-2:0], 1'b0};
        end
    end

    // pin outputs
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b1;
        unique case (state)
            ST_IDLE: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b1;
            end
            ST_PREAMBLE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_START, ST_OPCODE, ST_PHYADDR, ST_REGADDR: begin
                mdio_oe = 1'b1;
                mdio_o  = shreg[BODY_BITS-1];
            end
            ST_TURN, ST_DATA: begin
                mdio_oe = !rd_q;
                mdio_o  = shreg[BODY_BITS-1];
            end
        endcase
    end
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              active,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output logic [31:0]       reg_rdata
);
    logic              rd_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] reg_q;
    logic [DATA_W-1:0] data_q;
    logic              unused_rsvd;

    assign unused_rsvd = ^reg_wdata[RD_POS-1:PHY_LSB+ADDR_W];
    assign start       = reg_wr && reg_wdata[REQ_POS] && !active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            phy_q  <= '0;
            reg_q  <= '0;
            data_q <= '0;
        end else if (start) begin
            rd_q   <= reg_wdata[RD_POS];
            phy_q  <= reg_wdata[PHY_LSB +: ADDR_W];
            reg_q  <= reg_wdata[REG_LSB +: ADDR_W];
            data_q <= reg_wdata[DATA_W-1:0];
        end else if (done && rd_q) begin
            data_q <= rd_data;
        end
    end

    always_comb begin
        reg_rdata                      = '0;
        reg_rdata[REQ_POS]             = active;
        reg_rdata[RD_POS]              = rd_q;
        reg_rdata[PHY_LSB +: ADDR_W]   = phy_q;
        reg_rdata[REG_LSB +: ADDR_W]   = reg_q;
        reg_rdata[DATA_W-1:0]          = data_q;
    end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int CLK_DIV = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              start;
    logic              active;
    logic              done;
    logic              rise_tick;
    logic              fall_tick;
    logic [DATA_W-1:0] rd_data;

    mdio_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .active    (active),
        .done      (done),
        .rd_data   (rd_data),
        .start     (start),
        .reg_rdata (reg_rdata)
    );

    mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_read   (reg_wdata[RD_POS]),
        .phy_addr  (reg_wdata[PHY_LSB +: ADDR_W]),
        .reg_addr  (reg_wdata[REG_LSB +: ADDR_W]),
        .wr_data   (reg_wdata[DATA_W-1:0]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .active    (active),
        .done      (done),
        .rd_data   (rd_data),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    a_r2_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[31]) |-> (mdio_oe && mdio_o && !mdc));

    a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o));

    a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] && !reg_rdata[30]) |-> mdio_oe);

    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] && $past(reg_rdata[31])) |-> $stable(reg_rdata[30:0]));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> (!mdc && !mdio_oe));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio_cmd_master.sv
module test_mdio_cmd_master;
    localparam int DIV       = 3;
    localparam int FRAME_CYC = 128 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    mdio_cmd_master #(.CLK_DIV(DIV)) i_mdio_cmd_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // inputs seen by the design at each rising edge
    logic        s_wr = 1'b0, s_rst = 1'b0;
    logic [31:0] s_wdata = '0;
    always @(posedge clk) begin
        s_wr    <= reg_wr;
        s_wdata <= reg_wdata;
        s_rst   <= rst_n;
    end

    // behavioural reference model, advanced once per clock
    int          m_n = -1;
    bit          m_rd = 0;
    logic [4:0]  m_phy = '0, m_reg = '0;
    logic [15:0] m_data = '0;
    logic [63:0] m_frame = '0;
    logic [15:0] phy_reply = '0;

    always @(negedge clk) begin
        bit          busy;
        bit          e_mdc, e_oe;
        int          bitn;
        logic [31:0] e_rd;
        if (!s_rst) begin
            m_n = -1; m_rd = 0; m_phy = '0; m_reg = '0; m_data = '0;
        end else if (m_n >= 0) begin
            m_n++;
            if (m_n == FRAME_CYC) begin
                m_n = -1;
                if (m_rd) m_data = phy_reply;
            end
        end else if (s_wr && s_wdata[31]) begin
            m_n    = 0;
            m_rd   = s_wdata[30];
            m_phy  = s_wdata[25:21];
            m_reg  = s_wdata[20:16];
            m_data = s_wdata[15:0];
            m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01),
                       m_phy, m_reg, 2'b10, s_wdata[15:0]};
        end
        busy  = (m_n >= 0);
        bitn  = busy ? m_n / (2 * DIV) : 0;
        e_mdc = busy ? (((m_n / DIV) % 2) == 1) : 1'b0;
        e_oe  = busy && (!m_rd || bitn < 46);
        e_rd  = {busy, m_rd, 4'b0000, m_phy, m_reg, m_data};
        if (s_rst) begin
            check(mdc === e_mdc, "R3/R9 mdc", {31'b0, mdc}, {31'b0, e_mdc});
            check(mdio_oe === e_oe, "R6/R9 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe)  // R5: value only moves at falling MDC, held otherwise
                check(mdio_o === m_frame[63-bitn], "R4/R5 mdio_o",
                      {31'b0, mdio_o}, {31'b0, m_frame[63-bitn]});
            check(reg_rdata[31] === busy, "R2 busy", reg_rdata, e_rd);
            check(reg_rdata[30:0] === e_rd[30:0], "R1/R7 fields", reg_rdata, e_rd);
        end
        mdio_i = (busy && m_rd && bitn >= 48) ? phy_reply[63-bitn] : 1'b1;
    end

    function automatic logic [31:0] cmd(input bit go, input bit rd,
                                        input logic [4:0] phy, input logic [4:0] ra,
                                        input logic [15:0] d);
        return {go, rd, 4'b0000, phy, ra, d};
    endfunction

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (reg_rdata[31]) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        int          cyc;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        check(reg_rdata === 32'h0, "R1 reset word", reg_rdata, 32'h0);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R9 reset pins",
              {30'b0, mdc, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: write with alternating patterns
        issue(cmd(1, 0, 5'h15, 5'h0A, 16'hA55A));
        check(reg_rdata[31] === 1'b1, "R2 busy after write", reg_rdata, 32'h8000_0000);
        wait_idle(cyc);
        check(cyc == FRAME_CYC, "R3 busy length", cyc, FRAME_CYC);

        // R7: read, PHY returns a mixed pattern
        phy_reply = 16'hC3E1;
        issue(cmd(1, 1, 5'h1F, 5'h00, 16'h1234));
        repeat (50) @(negedge clk);
        snap = reg_rdata;
        // R8: command during a running frame is dropped
        issue(cmd(1, 0, 5'h02, 5'h03, 16'hFFFF));
        check(reg_rdata === snap, "R8 write while busy", reg_rdata, snap);
        wait_idle(cyc);
        check(reg_rdata === {1'b0, 1'b1, 4'b0, 5'h1F, 5'h00, 16'hC3E1},
              "R7 read result", reg_rdata, {1'b0, 1'b1, 4'b0, 5'h1F, 5'h00, 16'hC3E1});

        // R8: go flag clear while idle does nothing
        snap = reg_rdata;
        issue(cmd(0, 0, 5'h07, 5'h07, 16'h0F0F));
        repeat (DIV * 3) @(negedge clk);
        check(reg_rdata === snap && mdc === 1'b0, "R8 no-go write",
              reg_rdata, snap);

        // R9: back-to-back commands at the edge busy clears
        phy_reply = 16'h0001;
        issue(cmd(1, 1, 5'h00, 5'h1F, 16'h0000));
        wait_idle(cyc);
        check(reg_rdata[15:0] === 16'h0001, "R7 read low bit", reg_rdata, 32'h0001);
        reg_wr = 1'b1; reg_wdata = cmd(1, 0, 5'h00, 5'h11, 16'hFFFF);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check(reg_rdata[31] === 1'b1, "R9 restart right after idle",
              reg_rdata, 32'h8000_0000);
        wait_idle(cyc);
        check(cyc == FRAME_CYC, "R3 second busy length", cyc, FRAME_CYC);
        phy_reply = 16'h8000;
        issue(cmd(1, 1, 5'h0A, 5'h15, 16'h0000));
        wait_idle(cyc);
        check(reg_rdata[15:0] === 16'h8000, "R7 read high bit", reg_rdata, 32'h8000);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule